// File: doc/BRIEF.md
# Tag-Matching Reservation Station Bank

This block is a small pool of waiting slots that sits in front of one execution unit. An upstream dispatcher writes an operation into a free slot. Each of the two source operands arrives either as a ready value or as a non-zero producer tag, which names the slot or buffer that will later produce the value. The bank returns the tag of the slot it filled, so that later consumers can name this operation as their producer.

Every slot watches a result broadcast bus that carries a tag and a value. A slot whose pending tag equals the broadcast tag takes the value and drops the tag. When the unit reports that it is free, the bank hands it one slot whose operands are all values, choosing the oldest such slot. A younger slot that is ready may therefore pass an older slot that is still waiting. The issuing slot is released at the same clock edge.

Top module: `rsBank`

## Requirements
- R1: After reset no slot is occupied: `dispFull` is 0, `issueValid` is 0 even with `unitFree` high, and `dispSlotTag` equals `BASE_TAG`.
- R2: A dispatch goes into the lowest-numbered free slot. The tag of slot k is `BASE_TAG + k`, so with the default settings the first slot is tag 1. `dispSlotTag` shows this tag in the cycle of the dispatch.
- R3: An operand tag of 0 means the paired value field holds the operand. A non-zero tag means the operand is still pending. A slot with any pending operand is never issued.
- R4: When `bcastValid` is high and `bcastTag` equals a pending operand tag of an occupied slot, that operand takes `bcastVal` and becomes ready. The slot can issue from the cycle after the capture, not in the capture cycle.
- R5: A broadcast whose tag matches an operand tag that is being dispatched in the same cycle is captured at dispatch. The operand is stored as a ready value.
- R6: In a cycle where `unitFree` is high and at least one slot is ready, `issueValid` is high in that same cycle, and `issueOp`, `issueValA`, `issueValB` and `issueSlotTag` carry the chosen slot. When `unitFree` is low, `issueValid` is 0.
- R7: Among ready slots, the one dispatched earliest is issued. Ready slots are not held back by older slots that are still pending.
- R8: A slot is released at the clock edge on which it issues and can be refilled from the next cycle.
- R9: `dispFull` is high exactly when every slot is occupied. A dispatch offered while it is high is ignored and changes no slot.
- R10: A newly dispatched slot cannot issue in its own dispatch cycle. Its earliest issue cycle is the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispOp | input | OP_W | Operation code to hold |
| dispTagA | input | TAG_W | Producer tag of operand A, 0 if the value is supplied |
| dispValA | input | DATA_W | Value of operand A |
| dispTagB | input | TAG_W | Producer tag of operand B, 0 if the value is supplied |
| dispValB | input | DATA_W | Value of operand B |
| dispFull | output | 1 | All slots occupied, dispatch refused |
| dispSlotTag | output | TAG_W | Tag of the slot a dispatch fills this cycle |
| bcastValid | input | 1 | Result broadcast present |
| bcastTag | input | TAG_W | Tag of the broadcasting producer |
| bcastVal | input | DATA_W | Broadcast result value |
| unitFree | input | 1 | Execution unit can accept an operation |
| issueValid | output | 1 | A slot is handed to the unit this cycle |
| issueOp | output | OP_W | Operation of the issued slot |
| issueValA | output | DATA_W | Operand A of the issued slot |
| issueValB | output | DATA_W | Operand B of the issued slot |
| issueSlotTag | output | TAG_W | Tag of the issued slot |

## Verification
The bench builds the bank with its defaults: three slots, 4-bit tags, and slot tags 1 to 3. With only three slots, a full bank and a refused fourth dispatch can be reached within a few cycles. External producer tags such as 7 and 9 never collide with the bank's own slot tags, so the bench can tell a snooped value from a chained one. The small depth also makes the priority corner short to set up: one pending old slot followed by two ready younger ones.

// File: rtl/rsPkg.sv
package rsPkg;
  // Slot indices travel in a fixed-width field; banks hold at most 8 slots.
  parameter int SLOT_IDX_W = 3;

  typedef struct packed {
    logic                  loadEn;
    logic [SLOT_IDX_W-1:0] loadIdx;
    logic                  fireEn;
    logic [SLOT_IDX_W-1:0] fireIdx;
  } rsStrobes_t;
endpackage

// File: rtl/rsCtrl.sv
module rsCtrl
  import rsPkg::*;
#(
  parameter int NUM_ENTRIES = 3,
  parameter int AGE_W       = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dispValid,
  input  logic                   unitFree,
  input  logic [NUM_ENTRIES-1:0] pendingVec,
  output rsStrobes_t             strobes,
  output logic                   dispFull
);
  logic [NUM_ENTRIES-1:0] validQ;
  logic [AGE_W-1:0]       ageQ [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] readyVec;
  logic                   freeFound;
  logic [SLOT_IDX_W-1:0]  freeIdx;
  logic                   pickFound;
  logic [SLOT_IDX_W-1:0]  pickIdx;
  logic [AGE_W-1:0]       pickAge;

  // lowest-numbered free slot
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!validQ[i]) begin
        freeFound = 1'b1;
        freeIdx   = SLOT_IDX_W'(i);
      end
    end
  end

  assign readyVec = validQ & ~pendingVec;

  // oldest ready slot: larger rank means dispatched earlier
  always_comb begin
    pickFound = 1'b0;
    pickIdx   = '0;
    pickAge   = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (readyVec[i] && (!pickFound || ageQ[i] > pickAge)) begin
        pickFound = 1'b1;
        pickIdx   = SLOT_IDX_W'(i);
        pickAge   = ageQ[i];
      end
    end
  end

  always_comb begin
    strobes.loadEn  = dispValid & freeFound;
    strobes.loadIdx = freeIdx;
    strobes.fireEn  = unitFree & pickFound;
    strobes.fireIdx = pickIdx;
  end

  assign dispFull = ~freeFound;

  // Occupancy and rank: every dispatch ages the others by one; an issue
  // pulls the slots older than the issued one down by one, keeping ranks
  // dense in 0..count-1.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) ageQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strobes.loadEn && strobes.loadIdx == SLOT_IDX_W'(i)) begin
          validQ[i] <= 1'b1;
          ageQ[i]   <= '0;
        end else if (strobes.fireEn && strobes.fireIdx == SLOT_IDX_W'(i)) begin
          validQ[i] <= 1'b0;
        end else if (validQ[i]) begin
          ageQ[i] <= ageQ[i] + AGE_W'(strobes.loadEn)
                     - AGE_W'(strobes.fireEn && (ageQ[i] > pickAge));
        end
      end
    end
  end

  // R9
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dispFull && dispValid) |=> ($countones(validQ) <= $past($countones(validQ))))
    else $error("dispatch taken while full");

  // R8
  slot_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fireEn |=> ($countones(validQ) ==
      $past($countones(validQ)) - 1 + int'($past(strobes.loadEn))))
    else $error("issued slot not released");

  always_ff @(posedge clk) begin
    if (rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        // R3
        if (strobes.fireEn && strobes.fireIdx == SLOT_IDX_W'(i))
          fire_ready_chk: assert (validQ[i] && !pendingVec[i])
            else $error("issued slot %0d not ready", i);
        // R7
        if (strobes.fireEn && validQ[i] && !pendingVec[i])
          oldest_pick_chk: assert (ageQ[i] <= pickAge)
            else $error("older ready slot %0d skipped", i);
        // R7
        for (int j = i + 1; j < NUM_ENTRIES; j++)
          if (validQ[i] && validQ[j])
            rank_unique_chk: assert (ageQ[i] != ageQ[j])
              else $error("slots %0d and %0d share a rank", i, j);
      end
    end
  end
endmodule

// File: rtl/rsData.sv
module rsData
  import rsPkg::*;
#(
  parameter int NUM_ENTRIES = 3,
  parameter int TAG_W       = 4,
  parameter int DATA_W      = 32,
  parameter int OP_W        = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rsStrobes_t             strobes,
  input  logic [OP_W-1:0]        dispOp,
  input  logic [TAG_W-1:0]       dispTagA,
  input  logic [DATA_W-1:0]      dispValA,
  input  logic [TAG_W-1:0]       dispTagB,
  input  logic [DATA_W-1:0]      dispValB,
  input  logic                   bcastValid,
  input  logic [TAG_W-1:0]       bcastTag,
  input  logic [DATA_W-1:0]      bcastVal,
  output logic [NUM_ENTRIES-1:0] pendingVec,
  output logic [OP_W-1:0]        issueOp,
  output logic [DATA_W-1:0]      issueValA,
  output logic [DATA_W-1:0]      issueValB
);
  logic [OP_W-1:0]   opQ   [NUM_ENTRIES];
  logic [TAG_W-1:0]  tagAQ [NUM_ENTRIES];
  logic [DATA_W-1:0] valAQ [NUM_ENTRIES];
  logic [TAG_W-1:0]  tagBQ [NUM_ENTRIES];
  logic [DATA_W-1:0] valBQ [NUM_ENTRIES];

  logic hitDispA, hitDispB;
  assign hitDispA = bcastValid && (dispTagA != '0) && (bcastTag == dispTagA);
  assign hitDispB = bcastValid && (dispTagB != '0) && (bcastTag == dispTagB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        opQ[i]   <= '0;
        tagAQ[i] <= '0;
        valAQ[i] <= '0;
        tagBQ[i] <= '0;
        valBQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strobes.loadEn && strobes.loadIdx == SLOT_IDX_W'(i)) begin
          opQ[i]   <= dispOp;
          tagAQ[i] <= hitDispA ? '0 : dispTagA;
          valAQ[i] <= hitDispA ? bcastVal : dispValA;
          tagBQ[i] <= hitDispB ? '0 : dispTagB;
          valBQ[i] <= hitDispB ? bcastVal : dispValB;
        end else begin
          if (bcastValid && tagAQ[i] != '0 && bcastTag == tagAQ[i]) begin
            tagAQ[i] <= '0;
            valAQ[i] <= bcastVal;
          end
          if (bcastValid && tagBQ[i] != '0 && bcastTag == tagBQ[i]) begin
            tagBQ[i] <= '0;
            valBQ[i] <= bcastVal;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++)
      pendingVec[i] = (tagAQ[i] != '0) || (tagBQ[i] != '0);
  end

  always_comb begin
    issueOp   = '0;
    issueValA = '0;
    issueValB = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (strobes.fireEn && strobes.fireIdx == SLOT_IDX_W'(i)) begin
        issueOp   = opQ[i];
        issueValA = valAQ[i];
        issueValB = valBQ[i];
      end
    end
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gSnoop
    // R4
    capture_a_chk: assert property (@(posedge clk) disable iff (!rstN)
      (bcastValid && tagAQ[g] != '0 && bcastTag == tagAQ[g] &&
       !(strobes.loadEn && strobes.loadIdx == SLOT_IDX_W'(g)))
      |=> (tagAQ[g] == '0 && valAQ[g] == $past(bcastVal)))
      else $error("operand A of slot %0d missed broadcast", g);
    // R4
    capture_b_chk: assert property (@(posedge clk) disable iff (!rstN)
      (bcastValid && tagBQ[g] != '0 && bcastTag == tagBQ[g] &&
       !(strobes.loadEn && strobes.loadIdx == SLOT_IDX_W'(g)))
      |=> (tagBQ[g] == '0 && valBQ[g] == $past(bcastVal)))
      else $error("operand B of slot %0d missed broadcast", g);
  end
endmodule

// File: rtl/rsBank.sv
module rsBank
  import rsPkg::*;
#(
  parameter int NUM_ENTRIES = 3,
  parameter int TAG_W       = 4,
  parameter int DATA_W      = 32,
  parameter int OP_W        = 4,
  parameter int BASE_TAG    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dispValid,
  input  logic [OP_W-1:0]   dispOp,
  input  logic [TAG_W-1:0]  dispTagA,
  input  logic [DATA_W-1:0] dispValA,
  input  logic [TAG_W-1:0]  dispTagB,
  input  logic [DATA_W-1:0] dispValB,
  output logic              dispFull,
  output logic [TAG_W-1:0]  dispSlotTag,
  input  logic              bcastValid,
  input  logic [TAG_W-1:0]  bcastTag,
  input  logic [DATA_W-1:0] bcastVal,
  input  logic              unitFree,
  output logic              issueValid,
  output logic [OP_W-1:0]   issueOp,
  output logic [DATA_W-1:0] issueValA,
  output logic [DATA_W-1:0] issueValB,
  output logic [TAG_W-1:0]  issueSlotTag
);
  localparam int AGE_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  rsStrobes_t             strobes;
  logic [NUM_ENTRIES-1:0] pendingVec;

  rsCtrl #(.NUM_ENTRIES(NUM_ENTRIES), .AGE_W(AGE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .unitFree(unitFree),
    .pendingVec(pendingVec), .strobes(strobes), .dispFull(dispFull)
  );

  rsData #(.NUM_ENTRIES(NUM_ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .dispOp(dispOp), .dispTagA(dispTagA), .dispValA(dispValA),
    .dispTagB(dispTagB), .dispValB(dispValB),
    .bcastValid(bcastValid), .bcastTag(bcastTag), .bcastVal(bcastVal),
    .pendingVec(pendingVec), .issueOp(issueOp),
    .issueValA(issueValA), .issueValB(issueValB)
  );

  assign issueValid   = strobes.fireEn;
  assign dispSlotTag  = TAG_W'(BASE_TAG) + TAG_W'(strobes.loadIdx);
  assign issueSlotTag = TAG_W'(BASE_TAG) + TAG_W'(strobes.fireIdx);

  // R6
  busy_unit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !unitFree |-> !issueValid)
    else $error("issue while unit busy");
endmodule

// File: tb/tb_rsBank.sv
module tb_rsBank;
  logic        clk = 1'b0;
  logic        rstN;
  logic        dispValid;
  logic [3:0]  dispOp;
  logic [3:0]  dispTagA, dispTagB;
  logic [31:0] dispValA, dispValB;
  logic        dispFull;
  logic [3:0]  dispSlotTag;
  logic        bcastValid;
  logic [3:0]  bcastTag;
  logic [31:0] bcastVal;
  logic        unitFree;
  logic        issueValid;
  logic [3:0]  issueOp;
  logic [31:0] issueValA, issueValB;
  logic [3:0]  issueSlotTag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rsBank dut (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispOp(dispOp),
    .dispTagA(dispTagA), .dispValA(dispValA), .dispTagB(dispTagB), .dispValB(dispValB),
    .dispFull(dispFull), .dispSlotTag(dispSlotTag),
    .bcastValid(bcastValid), .bcastTag(bcastTag), .bcastVal(bcastVal),
    .unitFree(unitFree), .issueValid(issueValid), .issueOp(issueOp),
    .issueValA(issueValA), .issueValB(issueValB), .issueSlotTag(issueSlotTag)
  );

  // op, value A, value B: all operands ready at dispatch
  localparam logic [67:0] VEC [4] = '{
    {4'h1, 32'h0000_0011, 32'h0000_0022},
    {4'h2, 32'hDEAD_BEEF, 32'h0000_0000},
    {4'hF, 32'hFFFF_FFFF, 32'h1234_5678},
    {4'h0, 32'h0000_0000, 32'h8000_0001}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic quiet();
    dispValid = 0; dispOp = 0; dispTagA = 0; dispValA = 0; dispTagB = 0; dispValB = 0;
    bcastValid = 0; bcastTag = 0; bcastVal = 0;
  endtask

  task automatic nextCyc();
    @(negedge clk);
    quiet();
  endtask

  task automatic disp(input logic [3:0] op, input logic [3:0] ta, input logic [31:0] va,
                      input logic [3:0] tb, input logic [31:0] vb);
    dispValid = 1; dispOp = op; dispTagA = ta; dispValA = va; dispTagB = tb; dispValB = vb;
  endtask

  task automatic bcast(input logic [3:0] t, input logic [31:0] v);
    bcastValid = 1; bcastTag = t; bcastVal = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    quiet();
    unitFree = 0;
    rstN = 0;
    repeat (3) @(negedge clk);
    unitFree = 1;
    #1;
    // R1 reset state
    eq("R1 dispFull", dispFull, 0);
    eq("R1 issueValid", issueValid, 0);
    eq("R1 dispSlotTag", dispSlotTag, 1);
    rstN = 1;

    // Table walk: R2, R6, R8, R10
    for (int v = 0; v < 4; v++) begin
      nextCyc();
      unitFree = 1;
      disp(VEC[v][67:64], 0, VEC[v][63:32], 0, VEC[v][31:0]);
      #1;
      eq("R2 slot tag", dispSlotTag, 1);
      eq("R10 no same-cycle issue", issueValid, 0);
      nextCyc(); #1;
      eq("R6 issueValid", issueValid, 1);
      eq("R6 issueSlotTag", issueSlotTag, 1);
      eq("R6 issueOp", issueOp, VEC[v][67:64]);
      eq("R6 issueValA", issueValA, VEC[v][63:32]);
      eq("R6 issueValB", issueValB, VEC[v][31:0]);
      nextCyc(); #1;
      eq("R8 released", issueValid, 0);
    end

    // RAW chain: R3, R4
    unitFree = 0;
    nextCyc(); disp(4'h2, 0, 32'd10, 0, 32'd20); #1;
    eq("R2 first tag", dispSlotTag, 1);
    nextCyc(); disp(4'h3, 4'd1, 32'd0, 0, 32'd5); #1;
    eq("R2 second tag", dispSlotTag, 2);
    eq("R6 busy no issue", issueValid, 0);
    nextCyc(); unitFree = 1; #1;
    eq("R6 producer issues", issueSlotTag, 1);
    eq("R6 producer A", issueValA, 10);
    nextCyc(); #1;
    eq("R3 consumer waits", issueValid, 0);
    nextCyc(); bcast(4'd1, 32'd30); #1;
    eq("R4 not in capture cycle", issueValid, 0);
    nextCyc(); #1;
    eq("R4 consumer issues", issueValid, 1);
    eq("R4 consumer tag", issueSlotTag, 2);
    eq("R4 captured A", issueValA, 30);
    eq("R4 kept B", issueValB, 5);
    eq("R4 consumer op", issueOp, 3);
    nextCyc(); #1;
    eq("R8 bank empty", issueValid, 0);

    // Oldest-first with a pending old slot: R7, R9
    unitFree = 0;
    nextCyc(); disp(4'h4, 4'd9, 0, 0, 32'd1); #1;
    eq("R2 X tag", dispSlotTag, 1);
    nextCyc(); disp(4'h5, 0, 32'd2, 0, 32'd3); #1;
    eq("R2 Y tag", dispSlotTag, 2);
    nextCyc(); disp(4'h6, 0, 32'd4, 0, 32'd5); #1;
    eq("R9 not yet full", dispFull, 0);
    eq("R2 Z tag", dispSlotTag, 3);
    nextCyc(); disp(4'h7, 0, 32'd66, 0, 32'd67); #1;
    eq("R9 full", dispFull, 1);
    nextCyc(); unitFree = 1; #1;
    eq("R7 younger ready passes pending", issueValid, 1);
    eq("R7 oldest ready tag", issueSlotTag, 2);
    eq("R7 oldest ready op", issueOp, 5);
    nextCyc(); #1;
    eq("R7 next ready tag", issueSlotTag, 3);
    eq("R7 next ready A", issueValA, 4);
    nextCyc(); #1;
    eq("R9 refused dispatch absent", issueValid, 0);
    nextCyc(); bcast(4'd9, 32'd100); #1;
    eq("R4 capture cycle idle", issueValid, 0);
    nextCyc(); #1;
    eq("R3 X issues after broadcast", issueSlotTag, 1);
    eq("R4 X captured A", issueValA, 100);
    eq("R9 X op intact", issueOp, 4);
    nextCyc(); #1;
    eq("R9 no stray slot", issueValid, 0);

    // Broadcast during dispatch: R5
    nextCyc(); unitFree = 1; disp(4'h8, 4'd7, 32'd0, 0, 32'd2); bcast(4'd7, 32'd77); #1;
    eq("R10 dispatch cycle idle", issueValid, 0);
    nextCyc(); #1;
    eq("R5 issues next cycle", issueValid, 1);
    eq("R5 captured at dispatch", issueValA, 77);
    nextCyc(); #1;
    eq("R8 empty again", issueValid, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule